// File: doc/BRIEF.md
# Control OUT Packet Receive Buffer

This block stores one data-stage packet for the OUT direction of a USB device's control endpoint. A simplified serial-engine interface delivers the packet to it one byte per strobe. It then ends the packet with either a good or a bad end-of-packet pulse. Packets that belong to a SETUP transaction are marked by a qualifier and never enter this buffer.

A good packet of up to eight bytes is held. Its byte count is latched into a size register and a receive-complete flag is raised. The buffer then refuses further traffic with a NAK indication until the CPU releases it. The CPU walks the stored bytes through a read-only byte port. It releases the buffer with a read-finished pulse, or empties it at any time with a clear pulse. The flag is cleared by writing one and reaches an interrupt line through an enable.

Top module: `ctl_out_rxbuf`

## Requirements
- R1: Up to 8 bytes of one packet are stored and appear on `rd_data_o` in arrival order, one per read.
- R2: After reset `rd_data_o`, `rx_size_o`, `flag_o`, `irq_o` and `rx_nak_o` are all 0. A good end of packet carrying 0 to 8 bytes latches the count as a plain binary number into `rx_size_o`. It sets `flag_o` and drives `rx_nak_o` high, all on the clock edge that samples the end pulse.
- R3: Strobes and end pulses that arrive while `rx_setup_i` is 1 are ignored. Nothing is stored, and the flag and size do not change.
- R4: A packet that ends with `rx_eop_err_i`, or one with more than 8 bytes, is dropped. The flag stays clear, the size keeps its old value and the buffer stays armed.
- R5: While a packet is held, `rx_nak_o` is 1. Incoming bytes and end pulses then leave the stored data, the size and the flag unchanged.
- R6: `rd_data_o` shows the byte at the read pointer without delay. Each `rd_en_i` pulse advances the pointer. Reads beyond the latched count return 0, and `rd_data_o` is 0 while no packet is held.
- R7: A `rdfn_i` pulse re-arms the buffer: `rx_nak_o` falls, the read and write pointers return to 0 and `rx_size_o` is kept.
- R8: A `clr_i` pulse empties the buffer in the same way. It also discards bytes of a packet that is still arriving.
- R9: A `flag_clr_i` pulse clears `flag_o`. A flag set in the same cycle takes priority over the clear.
- R10: `irq_o` is 1 exactly when `flag_o` and `irq_en_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | One received byte present |
| rx_data_i | input | 8 | Received byte |
| rx_setup_i | input | 1 | Current traffic belongs to a SETUP packet |
| rx_eop_ok_i | input | 1 | Packet ended without error |
| rx_eop_err_i | input | 1 | Packet ended with error |
| rx_nak_o | output | 1 | Buffer held, new OUT data refused |
| rd_en_i | input | 1 | CPU read strobe, advances the read pointer |
| rd_data_o | output | 8 | Byte at the read pointer |
| rx_size_o | output | 4 | Byte count of the last accepted packet |
| rdfn_i | input | 1 | Read-finished trigger |
| clr_i | input | 1 | Buffer clear |
| flag_clr_i | input | 1 | Write-one clear of the receive-complete flag |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck held state shows at once as a NAK that does not fall one edge after the release pulse. A wrongly kept write pointer shows as a shifted first byte or a wrong count in the next accepted packet. An overflow or error path that accepts by mistake raises the flag and changes the size on the same edge as the bad end pulse. Corrupted storage or read-pointer logic shows within the first read of a packet, because every byte is compared against a scoreboard filled at send time.

// File: rtl/ctl_rxbuf_pkg.sv
package ctl_rxbuf_pkg;
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HELD  = 1'b1
  } buf_st_e;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wclr_i,
  input  logic          rd_adv_i,
  input  logic          rclr_i,
  input  logic          held_i,
  input  logic [PW-1:0] size_i,
  output logic [PW-1:0] wcnt_o,
  output logic          ovf_o,
  output logic [DW-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic          ovf_q;

  // contents carry no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_i && !wclr_i && wptr_q == PW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else if (wclr_i) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else if (wr_i) begin
      if (wptr_q == PW'(DEPTH)) ovf_q <= 1'b1;
      else                      wptr_q <= wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rptr_q <= '0;
    else if (rclr_i)                     rptr_q <= '0;
    else if (rd_adv_i && rptr_q < size_i) rptr_q <= rptr_q + 1'b1;
  end

  assign wcnt_o  = wptr_q;
  assign ovf_o   = ovf_q;
  assign rdata_o = (held_i && rptr_q < size_i) ? mem_q[rptr_q[AW-1:0]] : '0;

  AST_WPTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= PW'(DEPTH)); // R1
  AST_RPTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i |-> rptr_q <= size_i); // R6
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import ctl_rxbuf_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_setup_i,
  input  logic          eop_ok_i,
  input  logic          eop_err_i,
  input  logic          rdfn_i,
  input  logic          clr_i,
  input  logic [PW-1:0] wcnt_i,
  input  logic          ovf_i,
  output logic          wr_o,
  output logic          wclr_o,
  output logic          rclr_o,
  output logic          accept_o,
  output logic          held_o,
  output logic [PW-1:0] size_o
);
  buf_st_e       st_q;
  logic [PW-1:0] size_q;
  logic          release_w, armed_w, discard_w;

  assign release_w = rdfn_i | clr_i;
  assign armed_w   = (st_q == ST_ARMED) && !rx_setup_i && !release_w;
  assign wr_o      = armed_w && rx_valid_i;
  assign accept_o  = armed_w && eop_ok_i && !ovf_i;
  assign discard_w = armed_w && (eop_err_i || (eop_ok_i && ovf_i));
  assign wclr_o    = release_w | discard_w;
  assign rclr_o    = release_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ARMED;
      size_q <= '0;
    end else if (release_w) begin
      st_q   <= ST_ARMED;
    end else if (accept_o) begin
      st_q   <= ST_HELD;
      size_q <= wcnt_i;
    end
  end

  assign held_o = (st_q == ST_HELD);
  assign size_o = size_q;

  AST_HELD_SIZE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && $past(held_o)) |-> $stable(size_q)); // R5
  AST_RELEASE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> !held_o); // R7
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R9
endmodule

// File: rtl/ctl_out_rxbuf.sv
module ctl_out_rxbuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_setup_i,
  input  logic          rx_eop_ok_i,
  input  logic          rx_eop_err_i,
  output logic          rx_nak_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [PW-1:0] rx_size_o,
  input  logic          rdfn_i,
  input  logic          clr_i,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  output logic          flag_o,
  output logic          irq_o
);
  logic          wr_w, wclr_w, rclr_w, accept_w, held_w, ovf_w;
  logic [PW-1:0] wcnt_w, size_w;

  rxbuf_ctrl #(.PW(PW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_setup_i(rx_setup_i),
    .eop_ok_i(rx_eop_ok_i), .eop_err_i(rx_eop_err_i),
    .rdfn_i(rdfn_i), .clr_i(clr_i),
    .wcnt_i(wcnt_w), .ovf_i(ovf_w),
    .wr_o(wr_w), .wclr_o(wclr_w), .rclr_o(rclr_w),
    .accept_o(accept_w), .held_o(held_w), .size_o(size_w)
  );

  rxbuf_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_w), .wdata_i(rx_data_i), .wclr_i(wclr_w),
    .rd_adv_i(rd_en_i & held_w), .rclr_i(rclr_w),
    .held_i(held_w), .size_i(size_w),
    .wcnt_o(wcnt_w), .ovf_o(ovf_w), .rdata_o(rd_data_o)
  );

  rxbuf_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(accept_w), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  assign rx_nak_o  = held_w;
  assign rx_size_o = size_w;

  AST_ARMED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_nak_o |-> rd_data_o == '0); // R6
  AST_FLAG_RISE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> rx_nak_o); // R2
endmodule

// File: tb/ctl_out_rxbuf_tb.sv
`timescale 1ns/1ps
module ctl_out_rxbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_setup = 0, eop_ok = 0, eop_err = 0;
  logic [7:0] rx_data = 0;
  logic rd_en = 0, rdfn = 0, clr = 0, fclr = 0, irq_en = 0;
  logic nak, flag, irq;
  logic [7:0] rd_data;
  logic [3:0] size;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  ctl_out_rxbuf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_setup_i(rx_setup), .rx_eop_ok_i(eop_ok), .rx_eop_err_i(eop_err),
    .rx_nak_o(nak), .rd_en_i(rd_en), .rd_data_o(rd_data), .rx_size_o(size),
    .rdfn_i(rdfn), .clr_i(clr), .flag_clr_i(fclr), .irq_en_i(irq_en),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: sends a packet, queues bytes that should be stored
  task automatic send(int n, logic [7:0] seed, bit setup, bit good, bit expect_acc);
    rx_setup = setup;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = seed + 8'(i);
      if (expect_acc) exp_q.push_back(seed + 8'(i));
      @(negedge clk);
      rx_valid = 0;
    end
    if (good) eop_ok = 1; else eop_err = 1;
    @(negedge clk);
    eop_ok = 0; eop_err = 0; rx_setup = 0;
  endtask

  // monitor: pops expected bytes and compares port reads
  task automatic read_pkt(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      chk(req, rd_data, e);
      rd_en = 1; @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic pulse_rdfn(); rdfn = 1; @(negedge clk); rdfn = 0; endtask
  task automatic pulse_clr();  clr = 1;  @(negedge clk); clr = 0;  endtask
  task automatic pulse_fclr(); fclr = 1; @(negedge clk); fclr = 0; endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 rd_data", rd_data, 0); chk("R2 size", size, 0);
    chk("R2 flag", flag, 0); chk("R2 irq", irq, 0); chk("R2 nak", nak, 0);
    rst_n = 1; @(negedge clk);

    irq_en = 1;
    send(3, 8'hA0, 0, 1, 1);
    chk("R2 flag set", flag, 1); chk("R10 irq", irq, 1);
    chk("R2 size", size, 3); chk("R5 nak", nak, 1);
    read_pkt(3, "R1 data");
    chk("R6 past end", rd_data, 0);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R6 past end 2", rd_data, 0);
    pulse_rdfn();
    chk("R7 nak low", nak, 0); chk("R7 size kept", size, 3);
    pulse_fclr();
    chk("R9 flag clr", flag, 0); chk("R10 irq clr", irq, 0);

    // full packet, irq masked, then traffic while held
    irq_en = 0;
    send(8, 8'h10, 0, 1, 1);
    chk("R2 size 8", size, 8); chk("R10 masked", irq, 0);
    pulse_fclr();
    send(2, 8'hEE, 0, 1, 0);
    chk("R5 flag", flag, 0); chk("R5 size", size, 8); chk("R5 nak", nak, 1);
    read_pkt(8, "R5 data");
    pulse_rdfn();

    // SETUP traffic ignored
    send(3, 8'h55, 1, 1, 0);
    chk("R3 nak", nak, 0); chk("R3 flag", flag, 0); chk("R3 size", size, 8);
    send(2, 8'h30, 0, 1, 1);
    chk("R3 size", size, 2);
    read_pkt(2, "R3 data");
    pulse_rdfn(); pulse_fclr();

    // error and overlong packets dropped
    send(4, 8'h40, 0, 0, 0);
    chk("R4 err flag", flag, 0); chk("R4 err size", size, 2); chk("R4 err nak", nak, 0);
    send(9, 8'h60, 0, 1, 0);
    chk("R4 ovf flag", flag, 0); chk("R4 ovf size", size, 2); chk("R4 ovf nak", nak, 0);
    send(1, 8'h77, 0, 1, 1);
    chk("R4 rearmed size", size, 1);
    read_pkt(1, "R4 data");

    // clear while held, and clear mid-reception
    pulse_clr();
    chk("R8 nak", nak, 0); chk("R8 rd_data", rd_data, 0);
    pulse_fclr();
    rx_valid = 1; rx_data = 8'hC0; @(negedge clk);
    rx_data = 8'hC1; @(negedge clk); rx_valid = 0;
    pulse_clr();
    send(2, 8'h90, 0, 1, 1);
    chk("R8 size", size, 2);
    read_pkt(2, "R8 data");
    pulse_rdfn();

    // set wins over clear in the same cycle (flag already 1 here)
    rx_valid = 1; rx_data = 8'h21; exp_q.push_back(8'h21); @(negedge clk);
    rx_valid = 0; eop_ok = 1; fclr = 1; @(negedge clk);
    eop_ok = 0; fclr = 0;
    chk("R9 set wins", flag, 1);
    read_pkt(1, "R9 data");
    pulse_rdfn(); pulse_fclr();

    // zero-length packet
    send(0, 8'h00, 0, 1, 1);
    chk("R2 zlp flag", flag, 1); chk("R2 zlp size", size, 0);
    chk("R2 zlp nak", nak, 1); chk("R6 zlp data", rd_data, 0);
    irq_en = 1; #1;
    chk("R10 enable", irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule